// File: doc/BRIEF.md
# Multichannel DAC Streaming Controller

This block sits at an output port of a byte-wide switch fabric and feeds up to eight parallel-input DAC channels. Bytes arriving from the fabric are packed into 32-bit words, lowest byte first. Every word is either a command or a sample. A start command opens a session. It selects which channels take part and sets a divisor that slows the fixed update rate. Sample words carry a one-hot channel tag and a 16-bit value, and the value is kept in that channel's holding register.

At each update tick the block writes the held value of every enabled channel into the converter, one channel at a time and in ascending order. It then pulses the shared load strobe so that all outputs change together. A disconnect command closes the session and returns a one-cycle DONE pulse to the fabric. The base tick comes from a cycle counter, which is 500 clocks at 100 MHz for 200 kHz. The number of base ticks per update is set by the divisor.

Top module: `dacs_stream_ctrl`

## Requirements
- R1: Four accepted bytes form one 32-bit word; the first byte lands in bits 7:0 and the fourth in bits 31:24.
- R2: A word with bit 31 set and bit 30 clear starts a session: bits 7:0 become the channel enable mask (bit X enables channel X), bits 15:8 the rate divisor, and all holding registers become 0. Sample words received outside a session are ignored.
- R3: In a session the load strobe repeats every BASE_CYCLES × D clocks, where D is the divisor, and a divisor of 0 gives the same period as 1.
- R4: A word with bits 31 and 30 clear, bits 23:16 a one-hot tag for channel X and bits 15:0 a value stores that value for channel X. Every update tick writes each enabled channel's latest held value, repeating it when no new sample came.
- R5: A sample whose tag has zero or several bits set, or names a disabled channel, changes no holding register.
- R6: On an update, enabled channels are written in ascending order. Each write drives exactly one active-low chip select low for WR_CYC cycles, with the data bus stable throughout, and at most one chip select is ever low.
- R7: The active-low load strobe is low for one cycle, after the last enabled channel's chip select has risen, and only while all chip selects are high. With an empty mask there are no writes and no strobe.
- R8: A word with bit 30 set is a disconnect, even when bit 31 is also set. It yields a one-cycle DONE pulse and no further updates follow.
- R9: FULL is high for exactly the one cycle after the fourth byte of a word is accepted, and a byte presented during that cycle is dropped.
- R10: During reset the device reset output is low, read/not-write is high and reference enable (active low) is high. From the first clock after reset, device reset is high, read/not-write is low and reference enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fab_we_i | input | 1 | Byte strobe from the fabric |
| fab_data_i | input | 8 | Byte from the fabric |
| fab_full_o | output | 1 | Fabric must hold its byte |
| fab_done_o | output | 1 | One-cycle session-end pulse |
| dac_rnw_o | output | 1 | Read/not-write to the converters |
| dac_cs_n_o | output | NUM_CH | Per-channel chip select, active low |
| dac_ldac_n_o | output | 1 | Shared load strobe, active low |
| dac_rst_n_o | output | 1 | Converter reset, active low |
| dac_ref_en_n_o | output | 1 | Internal reference enable, active low |
| dac_data_o | output | DATA_W | Converter data bus |

## Verification
The bound checker watches the device-side handshake on every cycle. It checks that chip selects stay one-hot-or-idle, that each chip select is held and its data stays steady, and that the load strobe, DONE and FULL each last one cycle with the strobe falling only when all chip selects are high. It also checks the static device lines after reset. Whether the right value reaches the right channel, whether samples are dropped when they should be, the byte order and the update period all depend on the words that were sent. Only the scoreboard scenarios can show these, by comparing every observed write and strobe spacing against a model of the holding registers.

// File: rtl/dacs_pkg.sv
package dacs_pkg;
    localparam int WORD_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int START_BIT = 31;
    localparam int STOP_BIT  = 30;
    localparam int TAG_LO    = 16;
    localparam int DIV_LO    = 8;
    localparam int DIV_W     = 8;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_SLOT = 2'd1,
        WR_LOAD = 2'd2
    } wr_state_e;
endpackage

// File: rtl/dacs_word_asm.sv
module dacs_word_asm #(
    parameter int WORD_BYTES = 4
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           we_i,
    input  logic [dacs_pkg::BYTE_W-1:0]    byte_i,
    output logic                           word_vld_o,
    output logic [WORD_BYTES*dacs_pkg::BYTE_W-1:0] word_o
);
    localparam int BW    = dacs_pkg::BYTE_W;
    localparam int WW    = WORD_BYTES * BW;
    localparam int IDX_W = $clog2(WORD_BYTES);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [WW-1:0]    sh;
        logic             vld;
    } asm_t;

    asm_t asm_d, asm_q;

    always_comb begin
        asm_d     = asm_q;
        asm_d.vld = 1'b0;
        // a byte offered while the word is being handed on is dropped
        if (we_i && !asm_q.vld) begin
            asm_d.sh = {byte_i, asm_q.sh[WW-1:BW]};
            if (asm_q.idx == IDX_W'(WORD_BYTES - 1)) begin
                asm_d.idx = '0;
                asm_d.vld = 1'b1;
            end else begin
                asm_d.idx = asm_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) asm_q <= '0;
        else         asm_q <= asm_d;
    end

    assign word_vld_o = asm_q.vld;
    assign word_o     = asm_q.sh;
endmodule

// File: rtl/dacs_rate_gen.sv
module dacs_rate_gen #(
    parameter int BASE_CYCLES = 500
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        run_i,
    input  logic                        restart_i,
    input  logic [dacs_pkg::DIV_W-1:0]  div_i,
    output logic                        tick_o
);
    localparam int DW    = dacs_pkg::DIV_W;
    localparam int CNT_W = $clog2(BASE_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] base_cnt;
        logic [DW-1:0]    div_cnt;
    } rate_t;

    rate_t rate_d, rate_q;
    logic [DW-1:0] lim;
    logic          base_hit;
    logic          last_div;

    always_comb begin
        lim      = (div_i == '0) ? DW'(1) : div_i;
        base_hit = (rate_q.base_cnt == CNT_W'(BASE_CYCLES - 1));
        last_div = (rate_q.div_cnt == lim - DW'(1));
        tick_o   = run_i && base_hit && last_div;

        rate_d = rate_q;
        if (restart_i || !run_i) begin
            rate_d = '0;
        end else if (base_hit) begin
            rate_d.base_cnt = '0;
            rate_d.div_cnt  = last_div ? '0 : rate_q.div_cnt + 1'b1;
        end else begin
            rate_d.base_cnt = rate_q.base_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rate_q <= '0;
        else         rate_q <= rate_d;
    end
endmodule

// File: rtl/dacs_chan_writer.sv
module dacs_chan_writer #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 16,
    parameter int WR_CYC = 2
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           tick_i,
    input  logic [NUM_CH-1:0]              en_mask_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  hold_i,
    output logic [NUM_CH-1:0]              cs_n_o,
    output logic                           ldac_n_o,
    output logic [DATA_W-1:0]              data_o
);
    import dacs_pkg::*;

    localparam int CH_W = $clog2(NUM_CH);
    localparam int SC_W = $clog2(WR_CYC);

    typedef struct packed {
        wr_state_e           st;
        logic [CH_W-1:0]     ch;
        logic [SC_W-1:0]     cnt;
        logic [NUM_CH-1:0]   mask;
        logic [NUM_CH-1:0]   cs_n;
        logic                ldac_n;
        logic [DATA_W-1:0]   data;
    } wr_t;

    wr_t wr_d, wr_q;
    logic [CH_W:0] nx;

    // lowest enabled channel above 'after'; MSB flags that one exists
    function automatic logic [CH_W:0] next_en(input logic [NUM_CH-1:0] m, input int after);
        logic [CH_W:0] r;
        r = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (m[i] && (i > after)) r = {1'b1, CH_W'(i)};
        end
        return r;
    endfunction

    always_comb begin
        wr_d        = wr_q;
        wr_d.ldac_n = 1'b1;
        nx          = '0;
        unique case (wr_q.st)
            WR_IDLE: begin
                if (tick_i) begin
                    nx        = next_en(en_mask_i, -1);
                    wr_d.mask = en_mask_i;
                    if (nx[CH_W]) begin
                        wr_d.st   = WR_SLOT;
                        wr_d.ch   = nx[CH_W-1:0];
                        wr_d.cnt  = '0;
                        wr_d.data = hold_i[nx[CH_W-1:0]];
                        wr_d.cs_n = ~(NUM_CH'(1) << nx[CH_W-1:0]);
                    end
                end
            end
            WR_SLOT: begin
                if (wr_q.cnt == SC_W'(WR_CYC - 1)) begin
                    nx = next_en(wr_q.mask, int'(wr_q.ch));
                    if (nx[CH_W]) begin
                        wr_d.ch   = nx[CH_W-1:0];
                        wr_d.cnt  = '0;
                        wr_d.data = hold_i[nx[CH_W-1:0]];
                        wr_d.cs_n = ~(NUM_CH'(1) << nx[CH_W-1:0]);
                    end else begin
                        wr_d.st     = WR_LOAD;
                        wr_d.cs_n   = '1;
                        wr_d.ldac_n = 1'b0;
                    end
                end else begin
                    wr_d.cnt = wr_q.cnt + 1'b1;
                end
            end
            WR_LOAD: wr_d.st = WR_IDLE;
            default: wr_d.st = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wr_q        <= '0;
            wr_q.st     <= WR_IDLE;
            wr_q.cs_n   <= '1;
            wr_q.ldac_n <= 1'b1;
        end else begin
            wr_q <= wr_d;
        end
    end

    assign cs_n_o   = wr_q.cs_n;
    assign ldac_n_o = wr_q.ldac_n;
    assign data_o   = wr_q.data;
endmodule

// File: rtl/dacs_stream_ctrl.sv
module dacs_stream_ctrl #(
    parameter int NUM_CH      = 8,
    parameter int DATA_W      = 16,
    parameter int BASE_CYCLES = 500,
    parameter int WR_CYC      = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fab_we_i,
    input  logic [7:0]        fab_data_i,
    output logic              fab_full_o,
    output logic              fab_done_o,
    output logic              dac_rnw_o,
    output logic [NUM_CH-1:0] dac_cs_n_o,
    output logic              dac_ldac_n_o,
    output logic              dac_rst_n_o,
    output logic              dac_ref_en_n_o,
    output logic [DATA_W-1:0] dac_data_o
);
    import dacs_pkg::*;

    typedef struct packed {
        logic                          active;
        logic [NUM_CH-1:0]             mask;
        logic [DIV_W-1:0]              div;
        logic [NUM_CH-1:0][DATA_W-1:0] hold;
        logic                          done;
        logic                          rdy;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              word_vld;
    logic [WORD_W-1:0] word;
    logic [NUM_CH-1:0] tag;
    logic              tag_hit;
    logic              is_start;
    logic              is_stop;
    logic              restart;
    logic              tick;

    dacs_word_asm #(.WORD_BYTES(WORD_W / BYTE_W)) u_asm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .we_i       (fab_we_i),
        .byte_i     (fab_data_i),
        .word_vld_o (word_vld),
        .word_o     (word)
    );

    always_comb begin
        tag      = word[TAG_LO +: NUM_CH];
        is_stop  = word[STOP_BIT];
        is_start = word[START_BIT] && !word[STOP_BIT];
        restart  = word_vld && is_start;
        tag_hit  = (tag != '0) && ((tag & (tag - 1'b1)) == '0) && ((tag & ctl_q.mask) != '0);

        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.rdy  = 1'b1;
        if (word_vld) begin
            if (is_stop) begin
                ctl_d.active = 1'b0;
                ctl_d.done   = 1'b1;
            end else if (is_start) begin
                ctl_d.active = 1'b1;
                ctl_d.mask   = word[NUM_CH-1:0];
                ctl_d.div    = word[DIV_LO +: DIV_W];
                ctl_d.hold   = '0;
            end else if (ctl_q.active && tag_hit) begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (tag[i]) ctl_d.hold[i] = word[DATA_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    dacs_rate_gen #(.BASE_CYCLES(BASE_CYCLES)) u_rate (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (ctl_q.active),
        .restart_i (restart),
        .div_i     (ctl_q.div),
        .tick_o    (tick)
    );

    dacs_chan_writer #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .WR_CYC(WR_CYC)) u_wr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .en_mask_i (ctl_q.mask),
        .hold_i    (ctl_q.hold),
        .cs_n_o    (dac_cs_n_o),
        .ldac_n_o  (dac_ldac_n_o),
        .data_o    (dac_data_o)
    );

    assign fab_full_o     = word_vld;
    assign fab_done_o     = ctl_q.done;
    assign dac_rst_n_o    = ctl_q.rdy;
    assign dac_ref_en_n_o = !ctl_q.rdy;
    assign dac_rnw_o      = !ctl_q.rdy;
endmodule

// File: rtl/dacs_stream_ctrl_chk.sv
module dacs_stream_ctrl_chk #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              fab_full_o,
    input logic              fab_done_o,
    input logic              dac_rnw_o,
    input logic [NUM_CH-1:0] dac_cs_n_o,
    input logic              dac_ldac_n_o,
    input logic              dac_rst_n_o,
    input logic              dac_ref_en_n_o,
    input logic [DATA_W-1:0] dac_data_o
);
    p_single_cs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(~dac_cs_n_o) <= 1);

    p_cs_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dac_cs_n_o != '1 && dac_cs_n_o != $past(dac_cs_n_o)) |=> $stable(dac_cs_n_o));

    p_data_steady_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dac_cs_n_o != '1 && $stable(dac_cs_n_o)) |-> $stable(dac_data_o));

    p_load_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dac_ldac_n_o |-> (dac_cs_n_o == '1));

    p_load_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dac_ldac_n_o |=> dac_ldac_n_o);

    p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fab_done_o |=> !fab_done_o);

    p_full_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fab_full_o |=> !fab_full_o);

    p_dev_on_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (dac_rst_n_o && !dac_ref_en_n_o && !dac_rnw_o));
endmodule

bind dacs_stream_ctrl dacs_stream_ctrl_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .fab_full_o     (fab_full_o),
    .fab_done_o     (fab_done_o),
    .dac_rnw_o      (dac_rnw_o),
    .dac_cs_n_o     (dac_cs_n_o),
    .dac_ldac_n_o   (dac_ldac_n_o),
    .dac_rst_n_o    (dac_rst_n_o),
    .dac_ref_en_n_o (dac_ref_en_n_o),
    .dac_data_o     (dac_data_o)
);

// File: tb/tb_dacs_stream_ctrl.sv
module tb_dacs_stream_ctrl;
    localparam int NCH  = 8;
    localparam int DW   = 16;
    localparam int BASE = 80;
    localparam int WRC  = 2;

    typedef struct {
        int          ch;   // -1 marks the load strobe
        logic [15:0] val;
    } item_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           we = 1'b0;
    logic [7:0]     din = '0;
    logic           full, done, rnw, ldac_n, drst_n, ref_n;
    logic [NCH-1:0] cs_n;
    logic [DW-1:0]  dout;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int load_cnt = 0;
    int wr_cnt = 0;
    int per_exp = BASE;
    bit first_load = 1'b1;
    int last_load = 0;
    bit finished = 1'b0;

    item_t          exp_q[$];
    logic [NCH-1:0] m_mask = '0;
    logic [15:0]    m_hold[NCH];
    bit             m_active = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dacs_stream_ctrl #(.NUM_CH(NCH), .DATA_W(DW), .BASE_CYCLES(BASE), .WR_CYC(WRC)) dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .fab_we_i       (we),
        .fab_data_i     (din),
        .fab_full_o     (full),
        .fab_done_o     (done),
        .dac_rnw_o      (rnw),
        .dac_cs_n_o     (cs_n),
        .dac_ldac_n_o   (ldac_n),
        .dac_rst_n_o    (drst_n),
        .dac_ref_en_n_o (ref_n),
        .dac_data_o     (dout)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- monitor: pops expected items as writes appear ----------------
    logic [NCH-1:0] prev_cs = '1;
    int slot_len = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n != prev_cs && prev_cs != '1)
                chk(slot_len == WRC, "R6", "chip select width", slot_len, WRC);
            if (cs_n != '1) begin
                if (cs_n != prev_cs) begin
                    int ch = -1;
                    item_t it;
                    for (int i = 0; i < NCH; i++) if (!cs_n[i]) ch = i;
                    slot_len = 1;
                    wr_cnt++;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R4", "unexpected write on channel", ch, 0);
                    end else begin
                        it = exp_q.pop_front();
                        chk(it.ch == ch, "R6", "write order channel", ch, it.ch);
                        chk(it.val == dout, "R4", "written value", dout, it.val);
                    end
                end else begin
                    slot_len++;
                end
            end
            if (!ldac_n) begin
                item_t it;
                load_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected load strobe", 1, 0);
                end else begin
                    it = exp_q.pop_front();
                    chk(it.ch == -1, "R7", "load after last write (queue head)", it.ch, -1);
                end
                if (!first_load)
                    chk(cyc - last_load == per_exp, "R3", "update period", cyc - last_load, per_exp);
                first_load = 1'b0;
                last_load  = cyc;
            end
            prev_cs = cs_n;
        end
    end

    // ---------------- driver ----------------
    task automatic send_word(input logic [31:0] w, input bit poke);
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            we  = 1'b1;
            din = w[b*8 +: 8];
        end
        @(negedge clk);
        chk(full == 1'b1, "R9", "full after fourth byte", full, 1);
        if (poke) begin we = 1'b1; din = 8'hEE; end
        else we = 1'b0;
        @(negedge clk);
        we = 1'b0;
        chk(full == 1'b0, "R9", "full lasts one cycle", full, 0);
    endtask

    task automatic start(input logic [7:0] mask, input logic [7:0] div);
        first_load = 1'b1;
        per_exp    = BASE * ((div == 0) ? 1 : int'(div));
        send_word({2'b10, 14'd0, div, mask}, 1'b0);
        m_active = 1'b1;
        m_mask   = mask;
        for (int i = 0; i < NCH; i++) m_hold[i] = '0;
    endtask

    task automatic sample(input logic [7:0] tag, input logic [15:0] val, input bit poke);
        send_word({8'd0, tag, val}, poke);
        if (m_active && $onehot(tag) && ((tag & m_mask) != 0))
            for (int i = 0; i < NCH; i++) if (tag[i]) m_hold[i] = val;
    endtask

    task automatic expect_tick();
        int n0;
        item_t it;
        for (int i = 0; i < NCH; i++) begin
            if (m_mask[i]) begin
                it.ch = i; it.val = m_hold[i];
                exp_q.push_back(it);
            end
        end
        it.ch = -1; it.val = '0;
        exp_q.push_back(it);
        n0 = load_cnt;
        while (load_cnt == n0) @(negedge clk);
    endtask

    task automatic stop_word(input logic [31:0] w, input string tag);
        send_word(w, 1'b0);
        chk(done == 1'b1, "R8", {tag, " done pulse high"}, done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R8", {tag, " done pulse one cycle"}, done, 0);
        m_active = 1'b0;
    endtask

    initial begin
        int l0, w0;
        // R10 reset state
        repeat (3) @(negedge clk);
        chk(drst_n == 1'b0, "R10", "device reset low in reset", drst_n, 0);
        chk(rnw == 1'b1 && ref_n == 1'b1, "R10", "rnw/ref in reset", {rnw, ref_n}, 2'b11);
        chk(cs_n == '1 && ldac_n == 1'b1, "R7", "idle outputs in reset", {cs_n, ldac_n}, 9'h1FF);
        chk(full == 1'b0 && done == 1'b0, "R9", "full/done in reset", {full, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(drst_n && !rnw && !ref_n, "R10", "device lines after reset", {drst_n, rnw, ref_n}, 3'b100);

        // R2: sample with no session is ignored (ch2 must read 0 later)
        sample(8'h04, 16'h1234, 1'b0);

        // session A: mask 0xA5, divisor 1
        start(8'hA5, 8'd1);
        sample(8'h01, 16'h0102, 1'b0);          // R1 byte order
        sample(8'h20, 16'hBEEF, 1'b0);
        sample(8'h80, 16'h8001, 1'b0);
        sample(8'h02, 16'h5555, 1'b0);          // R5 disabled channel
        sample(8'h05, 16'h7777, 1'b0);          // R5 two tag bits
        expect_tick();                          // R2 R4 R5 R6 R7
        sample(8'h20, 16'h0A0B, 1'b0);
        expect_tick();                          // R3 R4 repeat of held values

        // session B: restart mid-session, all channels, divisor 0 acts as 1
        start(8'hFF, 8'd0);
        for (int i = 0; i < NCH; i++)
            sample(8'(1 << i), 16'(16'h1000 * i + i + 1), i == 3); // R9 byte poked while full
        expect_tick();
        expect_tick();                          // R3 divisor 0 period

        // session C: empty mask, R7 no writes and no strobe
        start(8'h00, 8'd1);
        l0 = load_cnt; w0 = wr_cnt;
        repeat (3 * BASE) @(negedge clk);
        chk(load_cnt == l0, "R7", "no strobe with empty mask", load_cnt, l0);
        chk(wr_cnt == w0, "R7", "no writes with empty mask", wr_cnt, w0);

        // session D: divisor 3
        start(8'h12, 8'd3);
        sample(8'h02, 16'hCAFE, 1'b0);
        sample(8'h10, 16'h0F0F, 1'b0);
        expect_tick();
        sample(8'h10, 16'h1111, 1'b0);
        expect_tick();                          // R3 three base periods

        // R8 disconnect stops updates
        stop_word(32'h4000_0000, "disconnect");
        l0 = load_cnt;
        repeat (2 * 3 * BASE) @(negedge clk);
        chk(load_cnt == l0, "R8", "no update after disconnect", load_cnt, l0);
        sample(8'h02, 16'h9999, 1'b0);          // ignored outside session

        // R8 both command bits: disconnect wins, no session starts
        stop_word(32'hC000_01FF, "both bits");
        l0 = load_cnt;
        repeat (3 * BASE) @(negedge clk);
        chk(load_cnt == l0, "R8", "no session after combined command", load_cnt, l0);
        chk(exp_q.size() == 0, "R4", "all expected writes seen", exp_q.size(), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule